// File: doc/BRIEF.md
# Flash Controller Configuration Register File

This block holds the software-visible settings of an embedded flash controller and the small amount of event state the controller reports back. A 32-bit peripheral register bus with a byte address, a write enable, byte strobes and write data reaches eight word registers. Read data is combinational from the register contents. The settings leave the block as plain signals: access mode, read-wait mode, lead-access wait count, and buffer enable and status.

The access mode is either 32-bit read-only ROM mode, which is the reset state, or 16-bit read/write programming mode. Entering programming mode forces the buffer enable and buffer status low and keeps them low. Two events come from the flash array: a corrected ECC error with its address, and a hang. Each event sets a sticky flag. Software clears a flag only by writing 1 to the matching bit of a separate clear register. The first ECC address is kept until software clears the ECC flag. A level interrupt request is raised while any flag is set and its enable bit is also set.

Top module: `flash_cfg_regs`

## Requirements
- R1: After reset the access mode is 2'b10 (ROM), the read-wait mode is 2'b11 (accelerator), the sync-down count is 0, buffer enable and status are 0, and both interrupt enables, both flags and the captured address are 0.
- R2: A write to the access register (byte offset 0x00, bits [1:0]) takes effect at the next clock edge only for 2'b01 (programming) or 2'b10 (ROM). Writes of 2'b00 and 2'b11 leave the field unchanged. `prog_mode` is 1 exactly when the field holds 2'b01.
- R3: While the access mode is programming, `buf_en` and `buf_stat` are 0. Both drop at the same edge that enters programming mode, and they stay 0 after a return to ROM until the enable is written again.
- R4: In the buffer register (offset 0x0C), bit 0 is the enable and bit 1 is the read-only status. In ROM mode, writing the enable updates it at the next edge. The status rises one cycle after the enable rises, falls together with it, and is never 1 while the enable is 0. An enable write made in programming mode is ignored.
- R5: The read-wait register (offset 0x04, bits [1:0]) accepts 2'b00 (zero wait), 2'b10 (four-cycle wait) and 2'b11 (accelerator). A write of 2'b01 is ignored.
- R6: The sync-down register (offset 0x08, bits [2:0]) accepts 3'd0 and 3'd1. Any larger value is ignored.
- R7: A register write changes a field only when byte strobe 0 is set. All unused bits and the clear register read 0, and the upper bits of a write are ignored.
- R8: The interrupt enable register (offset 0x10) holds the ECC enable at bit 2 and the hang enable at bit 1. `irq` equals the OR over bits 2 and 1 of (flags AND enables), and it is a level signal.
- R9: The status register (offset 0x14) is read-only. An ECC event sets bit 2 and a hang event sets bit 1 at the next edge, and each flag stays set until it is cleared.
- R10: Writing 1 to bit 2 or bit 1 of the clear register (offset 0x18) clears that flag at the next edge. Writing 0 has no effect. If a clear and an event for the same flag arrive in the same cycle, the flag stays set.
- R11: The capture register (offset 0x1C) loads the ECC address when an ECC event arrives while the ECC flag is clear or is being cleared in that cycle. Later ECC events do not overwrite it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 5 | Byte address of the register access |
| wr_en | input | 1 | Write strobe |
| be | input | 4 | Byte strobes of the write |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| ecc_evt | input | 1 | Corrected ECC error seen, one-cycle pulse |
| ecc_addr | input | 24 | Flash address of the ECC event |
| hang_evt | input | 1 | Hang detected, one-cycle pulse |
| acc_mode | output | 2 | Current access mode |
| prog_mode | output | 1 | Programming mode active |
| rd_wait | output | 2 | Read-wait mode |
| sync_wait | output | 3 | Wait cycles inserted on the lead flash access |
| buf_en | output | 1 | Buffer enable |
| buf_stat | output | 1 | Buffer running status |
| irq | output | 1 | Level interrupt request |

## Verification
Every field, flag and captured address changes at the first clock edge after the write or event cycle. The only exception is the buffer status, which follows one edge later, so it is due two edges after the enable write. `rdata` and `irq` are combinational from registered state. The bench drives each stimulus on a falling edge and holds it through exactly one rising edge. It then reads ports and `rdata` at the next falling edge, and it waits one more cycle only for the buffer status. Sweeps cover every access, read-wait and sync-down code written from each legal starting value, and every combination of the two enables and two flags.

// File: rtl/flash_cfg_pkg.sv
package flash_cfg_pkg;

    typedef enum logic [1:0] {
        ASZ_RSV0 = 2'b00,
        ASZ_PROG = 2'b01,
        ASZ_ROM  = 2'b10,
        ASZ_RSV3 = 2'b11
    } acc_size_e;

    typedef enum logic [1:0] {
        RW_ZERO  = 2'b00,
        RW_RSV   = 2'b01,
        RW_FOUR  = 2'b10,
        RW_ACCEL = 2'b11
    } rd_wait_e;

    // word index of each register (byte offset / 4)
    localparam int OFS_ACC   = 0;
    localparam int OFS_WAIT  = 1;
    localparam int OFS_SYNC  = 2;
    localparam int OFS_BUF   = 3;
    localparam int OFS_IEN   = 4;
    localparam int OFS_ISTAT = 5;
    localparam int OFS_ICLR  = 6;
    localparam int OFS_ECAP  = 7;
    localparam int NUM_REGS  = 8;

    localparam int IRQ_ECC_BIT  = 2;
    localparam int IRQ_HANG_BIT = 1;
    localparam int IRQ_W        = 3;
    localparam logic [IRQ_W-1:0] IRQ_MASK = 3'b110;

endpackage

// File: rtl/flash_cfg_mode.sv
module flash_cfg_mode
    import flash_cfg_pkg::*;
#(
    parameter int SYNC_W   = 3,
    parameter int SYNC_MAX = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_acc,
    input  logic              wr_wait,
    input  logic              wr_sync,
    input  logic              wr_buf,
    input  logic [7:0]        wbyte,
    output acc_size_e         acc_mode,
    output rd_wait_e          rd_wait,
    output logic [SYNC_W-1:0] sync_wait,
    output logic              buf_en,
    output logic              buf_stat
);
    localparam logic [SYNC_W-1:0] SYNC_LIM = SYNC_W'(SYNC_MAX);

    typedef struct packed {
        acc_size_e         acc;
        rd_wait_e          rwait;
        logic [SYNC_W-1:0] sync;
        logic              en;
        logic              stat;
    } mode_state_t;

    mode_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_acc && (wbyte[1:0] == ASZ_PROG || wbyte[1:0] == ASZ_ROM))
            st_d.acc = acc_size_e'(wbyte[1:0]);
        if (wr_wait && wbyte[1:0] != RW_RSV)
            st_d.rwait = rd_wait_e'(wbyte[1:0]);
        if (wr_sync && wbyte[SYNC_W-1:0] <= SYNC_LIM)
            st_d.sync = wbyte[SYNC_W-1:0];
        if (wr_buf)
            st_d.en = wbyte[0];
        if (st_d.acc == ASZ_PROG)
            st_d.en = 1'b0;
        st_d.stat = st_q.en & st_d.en;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{acc: ASZ_ROM, rwait: RW_ACCEL, sync: '0, en: 1'b0, stat: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign acc_mode  = st_q.acc;
    assign rd_wait   = st_q.rwait;
    assign sync_wait = st_q.sync;
    assign buf_en    = st_q.en;
    assign buf_stat  = st_q.stat;

    // R2
    acc_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_mode == ASZ_PROG) || (acc_mode == ASZ_ROM));

    // R2
    acc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr_acc) |-> $stable(acc_mode));

    // R3
    prog_buf_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_mode == ASZ_PROG) |-> (!buf_en && !buf_stat));

    // R4
    stat_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        buf_stat |-> buf_en);

    // R4
    stat_late_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(buf_stat) |-> $past(buf_en));

    // R5
    wait_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_wait != RW_RSV);

    // R6
    sync_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sync_wait <= SYNC_LIM);

endmodule

// File: rtl/flash_cfg_irq.sv
module flash_cfg_irq
    import flash_cfg_pkg::*;
#(
    parameter int FA_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_ien,
    input  logic             wr_clr,
    input  logic [7:0]       wbyte,
    input  logic             ecc_evt,
    input  logic [FA_W-1:0]  ecc_addr,
    input  logic             hang_evt,
    output logic [IRQ_W-1:0] ien,
    output logic [IRQ_W-1:0] iflag,
    output logic [FA_W-1:0]  cap_addr,
    output logic             irq
);
    typedef struct packed {
        logic [IRQ_W-1:0] en;
        logic [IRQ_W-1:0] flag;
        logic [FA_W-1:0]  cap;
    } irq_state_t;

    irq_state_t st_d, st_q;
    logic [IRQ_W-1:0] set_v, clr_v;

    always_comb begin
        set_v = '0;
        set_v[IRQ_ECC_BIT]  = ecc_evt;
        set_v[IRQ_HANG_BIT] = hang_evt;
        clr_v = wr_clr ? (wbyte[IRQ_W-1:0] & IRQ_MASK) : '0;
        st_d = st_q;
        if (wr_ien)
            st_d.en = wbyte[IRQ_W-1:0] & IRQ_MASK;
        st_d.flag = (st_q.flag & ~clr_v) | set_v;
        if (ecc_evt && (!st_q.flag[IRQ_ECC_BIT] || clr_v[IRQ_ECC_BIT]))
            st_d.cap = ecc_addr;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ien      = st_q.en;
    assign iflag    = st_q.flag;
    assign cap_addr = st_q.cap;
    assign irq      = |(st_q.flag & st_q.en);

    // R9
    ecc_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(iflag[IRQ_ECC_BIT]) |-> ($past(wr_clr) && $past(wbyte[IRQ_ECC_BIT])));

    // R9
    hang_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(iflag[IRQ_HANG_BIT]) |-> ($past(wr_clr) && $past(wbyte[IRQ_HANG_BIT])));

    // R10
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ecc_evt |=> iflag[IRQ_ECC_BIT]);

    // R11
    cap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(iflag[IRQ_ECC_BIT] && !(wr_clr && wbyte[IRQ_ECC_BIT])) |-> $stable(cap_addr));

endmodule

// File: rtl/flash_cfg_regs.sv
module flash_cfg_regs
    import flash_cfg_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int FA_W   = 24,
    parameter int SYNC_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [3:0]        be,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    input  logic              ecc_evt,
    input  logic [FA_W-1:0]   ecc_addr,
    input  logic              hang_evt,
    output logic [1:0]        acc_mode,
    output logic              prog_mode,
    output logic [1:0]        rd_wait,
    output logic [SYNC_W-1:0] sync_wait,
    output logic              buf_en,
    output logic              buf_stat,
    output logic              irq
);
    localparam int IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0]    idx;
    logic [NUM_REGS-1:0] wr_sel;
    acc_size_e           acc_e;
    rd_wait_e            wait_e;
    logic [IRQ_W-1:0]    ien, iflag;
    logic [FA_W-1:0]     cap_addr;
    logic                unused_bits;

    assign idx = addr[ADDR_W-1:2];
    assign unused_bits = ^{addr[1:0], be[3:1], wdata[31:8]};

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_dec
        assign wr_sel[g] = wr_en && be[0] && (idx == IDX_W'(g));
    end

    flash_cfg_mode #(.SYNC_W(SYNC_W), .SYNC_MAX(1)) mode_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_acc    (wr_sel[OFS_ACC]),
        .wr_wait   (wr_sel[OFS_WAIT]),
        .wr_sync   (wr_sel[OFS_SYNC]),
        .wr_buf    (wr_sel[OFS_BUF]),
        .wbyte     (wdata[7:0]),
        .acc_mode  (acc_e),
        .rd_wait   (wait_e),
        .sync_wait (sync_wait),
        .buf_en    (buf_en),
        .buf_stat  (buf_stat)
    );

    flash_cfg_irq #(.FA_W(FA_W)) irq_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_ien   (wr_sel[OFS_IEN]),
        .wr_clr   (wr_sel[OFS_ICLR]),
        .wbyte    (wdata[7:0]),
        .ecc_evt  (ecc_evt),
        .ecc_addr (ecc_addr),
        .hang_evt (hang_evt),
        .ien      (ien),
        .iflag    (iflag),
        .cap_addr (cap_addr),
        .irq      (irq)
    );

    assign acc_mode  = acc_e;
    assign rd_wait   = wait_e;
    assign prog_mode = (acc_e == ASZ_PROG);

    always_comb begin
        rdata = '0;
        case (int'(idx))
            OFS_ACC:   rdata[1:0]        = acc_e;
            OFS_WAIT:  rdata[1:0]        = wait_e;
            OFS_SYNC:  rdata[SYNC_W-1:0] = sync_wait;
            OFS_BUF:   rdata[1:0]        = {buf_stat, buf_en};
            OFS_IEN:   rdata[IRQ_W-1:0]  = ien;
            OFS_ISTAT: rdata[IRQ_W-1:0]  = iflag;
            OFS_ECAP:  rdata[FA_W-1:0]   = cap_addr;
            default:   rdata             = '0;
        endcase
    end

    // R8
    irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($past(ecc_evt) || $past(hang_evt) || $past(wr_sel[OFS_IEN])));

    // R7
    clr_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(idx) == OFS_ICLR) |-> (rdata == 32'd0));

endmodule

// File: tb/flash_cfg_regs_tb_top.sv
module flash_cfg_regs_tb_top;
    localparam int FA_W = 24;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic [3:0]  be = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        ecc_evt = 1'b0;
    logic [FA_W-1:0] ecc_addr = '0;
    logic        hang_evt = 1'b0;
    logic [1:0]  acc_mode;
    logic        prog_mode;
    logic [1:0]  rd_wait;
    logic [2:0]  sync_wait;
    logic        buf_en, buf_stat, irq;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    always #2 clk = ~clk;

    flash_cfg_regs dut_i (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .be(be),
        .wdata(wdata), .rdata(rdata), .ecc_evt(ecc_evt), .ecc_addr(ecc_addr),
        .hang_evt(hang_evt), .acc_mode(acc_mode), .prog_mode(prog_mode),
        .rd_wait(rd_wait), .sync_wait(sync_wait), .buf_en(buf_en),
        .buf_stat(buf_stat), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=0x%0h exp=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d, input logic [3:0] b);
        @(negedge clk);
        addr = a; wdata = d; be = b; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; be = '0;
    endtask

    task automatic rdchk(input string tag, input logic [4:0] a, input logic [31:0] exp);
        addr = a;
        #1;
        chk(tag, rdata, exp);
    endtask

    task automatic pulse(input logic e, input logic h, input logic [FA_W-1:0] ea);
        @(negedge clk);
        ecc_evt = e; hang_evt = h; ecc_addr = ea;
        @(negedge clk);
        ecc_evt = 1'b0; hang_evt = 1'b0;
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_fail++;
            n_run++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [1:0] cur;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 acc_mode", acc_mode, 2'b10);
        chk("R1 rd_wait", rd_wait, 2'b11);
        chk("R1 sync_wait", sync_wait, 0);
        chk("R1 buf", {buf_stat, buf_en}, 0);
        chk("R1 irq", irq, 0);
        rdchk("R1 ien", 5'h10, 0);
        rdchk("R1 istat", 5'h14, 0);
        rdchk("R1 ecap", 5'h1C, 0);

        // R2 access-size sweep from each legal start
        for (int s = 1; s <= 2; s++) begin
            for (int v = 0; v < 4; v++) begin
                wr(5'h00, 32'(s), 4'h1);
                wr(5'h00, 32'(v), 4'h1);
                cur = (v == 1 || v == 2) ? 2'(v) : 2'(s);
                chk($sformatf("R2 acc start=%0d wr=%0d", s, v), acc_mode, cur);
                chk("R2 prog_mode", prog_mode, cur == 2'b01);
                rdchk("R2 acc read", 5'h00, cur);
            end
        end

        // R4 buffer enable in ROM mode
        wr(5'h00, 32'h2, 4'h1);
        wr(5'h0C, 32'h1, 4'h1);
        chk("R4 en after write", buf_en, 1);
        chk("R4 stat lags", buf_stat, 0);
        @(negedge clk);
        chk("R4 stat rises", buf_stat, 1);
        rdchk("R4 buf read", 5'h0C, 32'h3);
        wr(5'h0C, 32'h0, 4'h1);
        chk("R4 stat falls with en", {buf_stat, buf_en}, 0);
        wr(5'h0C, 32'h1, 4'h1);
        @(negedge clk);

        // R3 programming mode forces buffer off
        wr(5'h00, 32'h1, 4'h1);
        chk("R3 forced off", {buf_stat, buf_en}, 0);
        wr(5'h0C, 32'h1, 4'h1);
        @(negedge clk);
        chk("R4 enable ignored in prog", {buf_stat, buf_en}, 0);
        rdchk("R3 buf read in prog", 5'h0C, 0);
        wr(5'h00, 32'h2, 4'h1);
        @(negedge clk);
        chk("R3 stays off in ROM", {buf_stat, buf_en}, 0);

        // R5 read-wait sweep
        for (int s = 0; s < 4; s++) begin
            if (s == 1) continue;
            for (int v = 0; v < 4; v++) begin
                wr(5'h04, 32'(s), 4'h1);
                wr(5'h04, 32'(v), 4'h1);
                cur = (v == 1) ? 2'(s) : 2'(v);
                chk($sformatf("R5 wait start=%0d wr=%0d", s, v), rd_wait, cur);
            end
        end

        // R6 sync-down sweep
        for (int s = 0; s < 2; s++) begin
            for (int v = 0; v < 8; v++) begin
                wr(5'h08, 32'(s), 4'h1);
                wr(5'h08, 32'(v), 4'h1);
                chk($sformatf("R6 sync start=%0d wr=%0d", s, v), sync_wait, (v <= 1) ? v : s);
            end
        end

        // R7 byte strobe and reserved bits
        wr(5'h04, 32'h0, 4'hE);
        chk("R7 no be0 no write", rd_wait, 2'b11);
        wr(5'h00, 32'hFFFF_FF01, 4'hF);
        rdchk("R7 upper bits dropped", 5'h00, 32'h1);
        wr(5'h00, 32'h2, 4'h1);
        wr(5'h18, 32'hFFFF_FFFF, 4'hF);
        rdchk("R7 clr reads 0", 5'h18, 0);

        // R8 enable x flag sweep
        for (int e = 0; e < 4; e++) begin
            for (int f = 0; f < 4; f++) begin
                wr(5'h18, 32'h6, 4'h1);
                wr(5'h10, 32'h0, 4'h1);
                pulse(f[1], f[0], 24'h0);
                wr(5'h10, 32'(e << 1), 4'h1);
                chk($sformatf("R8 irq en=%0d fl=%0d", e, f), irq, |(e & f));
                rdchk("R9 status", 5'h14, 32'(f << 1));
                rdchk("R8 enable read", 5'h10, 32'(e << 1));
            end
        end

        // R9/R10 clear behaviour
        wr(5'h18, 32'h6, 4'h1);
        wr(5'h10, 32'h6, 4'h1);
        pulse(1'b1, 1'b1, 24'h000123);
        wr(5'h14, 32'h0, 4'h1);
        rdchk("R9 status read-only", 5'h14, 32'h6);
        wr(5'h18, 32'h0, 4'h1);
        rdchk("R10 write 0 no effect", 5'h14, 32'h6);
        wr(5'h18, 32'h2, 4'h1);
        rdchk("R10 clear hang only", 5'h14, 32'h4);
        chk("R8 irq still ecc", irq, 1);

        // R11 capture holds first address
        rdchk("R11 first capture", 5'h1C, 32'h000123);
        pulse(1'b1, 1'b0, 24'hABCDEF);
        rdchk("R11 no overwrite", 5'h1C, 32'h000123);
        wr(5'h18, 32'h4, 4'h1);
        rdchk("R10 ecc cleared", 5'h14, 0);
        chk("R8 irq low", irq, 0);
        pulse(1'b1, 1'b0, 24'h00BEEF);
        rdchk("R11 new capture", 5'h1C, 32'h00BEEF);

        // R10 set wins over clear in same cycle, capture refreshed
        @(negedge clk);
        addr = 5'h18; wdata = 32'h4; be = 4'h1; wr_en = 1'b1;
        ecc_evt = 1'b1; ecc_addr = 24'h55AA55;
        @(negedge clk);
        wr_en = 1'b0; be = '0; ecc_evt = 1'b0;
        rdchk("R10 set wins", 5'h14, 32'h4);
        rdchk("R11 capture on clear+event", 5'h1C, 32'h55AA55);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule